// File: doc/BRIEF.md
# Serial Successive-Approximation Conversion Sequencer

This block is the digital sequencer inside an 8-bit serial converter that acts as a bus slave. It runs on a fast system clock and oversamples a slow serial clock, an active-low select, a serial data input and a one-bit comparator result. Once the host sends a start bit, the block takes in a channel address and flags a half-clock track window. It then runs a successive-approximation search on a trial register, resolving one bit on every falling serial-clock edge. Each decision appears on the serial output as soon as it is made, so the result goes out MSB first while the conversion is still running.

Once the last decision is out, the stored word is shifted out again LSB first. The final bit then stays on the line until the host deselects. The comparator and DAC sit outside the block: `cmp_below` reports whether the sampled input is below the level the trial register currently sets. The serial output carries a separate drive enable for the pad. A parameter selects a single-channel variant, which has no address phase and no LSB-first replay.

The serial link is a plain bit-serial protocol timed by the host's clock, so there is no valid/ready handshake and no back-pressure. The host sets the pace by stopping the serial clock or deselecting.

Top module: `sar_serial_seq`

## Requirements
- R1: After `rst_n` is released, `sdo_oe`, `sdo`, `busy` and `track` are 0 and `chan` is 0.
- R2: While idle, rising serial-clock edges that sample `sdi` = 0 are ignored and no conversion starts. Only a sampled 1 counts as a start bit.
- R3: After the start bit, the next `ADDR_W` rising edges shift `sdi` into `chan`, MSB first. `chan` keeps that value through and after the conversion.
- R4: `track` goes high on the rising edge that captures the last address bit (or the start bit in the single-channel variant). It goes low at the next falling edge, so the window lasts half a serial clock.
- R5: The trial register starts at 1000_0000. On each of 8 falling edges, the current trial bit is cleared when `cmp_below` = 1 and kept when it is 0, and the next lower bit is set. The final word equals the input level.
- R6: Each decision is driven on `sdo` by the falling edge that makes it. A decision bit is 1 when `cmp_below` = 0. Bits appear MSB first.
- R7: If `cmp_below` is 1 at every decision (negative input at or above positive input), the result is all zeros.
- R8: `busy` is high from the start of the track window until the falling edge that produces the last MSB-first bit.
- R9: In the multi-channel variant, the next 7 falling edges drive result bits 1 to 7 in that order. Bit 7 then stays on `sdo` until select is released, and releasing select then returns the block to idle.
- R10: With `cs_n` high, `sdo_oe` goes to 0 within 4 system cycles. The sequencer freezes and ignores serial-clock edges. When select returns, the sequencer resumes where it stopped and `sdo` still shows the last bit.
- R11: Holding `sclk` and `cs_n` both high for `RST_CYC` consecutive system cycles returns the sequencer to idle and clears `chan`. A shorter overlap has no effect.
- R12: With `SINGLE_CH` = 1 there is no address phase and no replay. The start bit opens the track window, and bit 0 stays on `sdo` after the last decision until deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select |
| sdi | input | 1 | Serial data in (start bit, then address) |
| cmp_below | input | 1 | Comparator: 1 when the input is below the trial level |
| sdo | output | 1 | Serial result bit |
| sdo_oe | output | 1 | Drive enable for the `sdo` pad; 0 means high impedance |
| busy | output | 1 | Conversion in progress |
| track | output | 1 | Half-clock acquisition window |
| chan | output | ADDR_W | Latched channel address |

## Verification
The hardest states to reach from the ports are a conversion paused in the middle and the boundary between a harmless clock-high overlap and a real reset. Both need select released while the trial register is only partly resolved. The stimulus drops select after the fourth decision of one table vector, pulses `sclk` for less than `RST_CYC` cycles while deselected, and then reselects and finishes. The word that comes out must match the model exactly. A separate directed test starts a conversion and holds both lines high past `RST_CYC`. It then confirms that `busy`, `track` and `chan` are cleared and that a fresh conversion still works.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_TRACK,
    ST_CONV,
    ST_REPLAY,
    ST_HOLD
  } seq_state_t;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sar_edge_rst.sv
module sar_edge_rst #(
  parameter int RST_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic cs_s,
  output logic rise_ev,
  output logic fall_ev,
  output logic rst_hit
);
  localparam int CW = $clog2(RST_CYC + 1);

  logic          sclk_d;
  logic [CW-1:0] cnt_q;
  logic          overlap;

  assign overlap = cs_s & sclk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sclk_d <= sclk_s;
      if (!overlap)                    cnt_q <= '0;
      else if (cnt_q != CW'(RST_CYC))  cnt_q <= cnt_q + CW'(1);
    end
  end

  assign rise_ev = sclk_s & ~sclk_d;
  assign fall_ev = ~sclk_s & sclk_d;
  assign rst_hit = overlap & (cnt_q == CW'(RST_CYC - 1));
endmodule

// File: rtl/sar_core.sv
module sar_core
  import sar_seq_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int ADDR_W = 3,
  parameter bit SINGLE_CH = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              sdi_s,
  input  logic              cmp_below_s,
  input  logic              rise_ev,
  input  logic              fall_ev,
  input  logic              rst_hit,
  output seq_state_t        state,
  output logic [WIDTH-1:0]  trial,
  output logic [ADDR_W-1:0] chan,
  output logic              sdo
);
  localparam int IW = $clog2(WIDTH);
  localparam int AW = $clog2(ADDR_W + 1);
  localparam logic [WIDTH-1:0] TRIAL_INIT = {1'b1, {(WIDTH-1){1'b0}}};
  localparam seq_state_t AFTER_CONV = SINGLE_CH ? ST_HOLD : ST_REPLAY;
  localparam seq_state_t AFTER_START = SINGLE_CH ? ST_TRACK : ST_ADDR;

  seq_state_t        state_q;
  logic [WIDTH-1:0]  trial_q, trial_d;
  logic [ADDR_W-1:0] chan_q;
  logic [ADDR_W:0]   chan_sh;
  logic              sdo_q;
  logic [IW-1:0]     idx_q;
  logic [AW-1:0]     acnt_q;

  always_comb begin
    trial_d = trial_q;
    trial_d[idx_q] = ~cmp_below_s;
    if (idx_q != '0) trial_d[idx_q - IW'(1)] = 1'b1;
  end

  assign chan_sh = {chan_q, sdi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      trial_q <= '0;
      chan_q  <= '0;
      sdo_q   <= 1'b0;
      idx_q   <= '0;
      acnt_q  <= '0;
    end else if (rst_hit) begin
      state_q <= ST_IDLE;
      trial_q <= '0;
      chan_q  <= '0;
      sdo_q   <= 1'b0;
      idx_q   <= '0;
      acnt_q  <= '0;
    end else if (cs_s) begin
      if (state_q == ST_HOLD) state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (rise_ev && sdi_s) begin
          state_q <= AFTER_START;
          trial_q <= TRIAL_INIT;
          acnt_q  <= '0;
          idx_q   <= IW'(WIDTH - 1);
        end
        ST_ADDR: if (rise_ev) begin
          chan_q <= chan_sh[ADDR_W-1:0];
          acnt_q <= acnt_q + AW'(1);
          if (acnt_q == AW'(ADDR_W - 1)) state_q <= ST_TRACK;
        end
        ST_TRACK, ST_CONV: if (fall_ev) begin
          trial_q <= trial_d;
          sdo_q   <= ~cmp_below_s;
          if (idx_q == '0) begin
            state_q <= AFTER_CONV;
            idx_q   <= IW'(1);
          end else begin
            state_q <= ST_CONV;
            idx_q   <= idx_q - IW'(1);
          end
        end
        ST_REPLAY: if (fall_ev) begin
          sdo_q <= trial_q[idx_q];
          if (idx_q == IW'(WIDTH - 1)) state_q <= ST_HOLD;
          else                         idx_q   <= idx_q + IW'(1);
        end
        default: ;
      endcase
    end
  end

  assign state = state_q;
  assign trial = trial_q;
  assign chan  = chan_q;
  assign sdo   = sdo_q;
endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
  import sar_seq_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int ADDR_W = 3,
  parameter bit SINGLE_CH = 1'b0,
  parameter int SYNC_STAGES = 2,
  parameter int RST_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdi,
  input  logic              cmp_below,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              busy,
  output logic              track,
  output logic [ADDR_W-1:0] chan
);
  logic [2:0]       raw_in, syn_in;
  logic             cs_s, sclk_s, sdi_s, cmp_s;
  logic             rise_ev, fall_ev, rst_hit;
  logic             oe_q;
  seq_state_t       state;
  logic [WIDTH-1:0] trial;

  assign raw_in = {sclk, sdi, cmp_below};
  assign sclk_s = syn_in[2];
  assign sdi_s  = syn_in[1];
  assign cmp_s  = syn_in[0];

  sar_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b000)) u_sync_data (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  sar_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s)
  );

  sar_edge_rst #(.RST_CYC(RST_CYC)) u_edge (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .cs_s(cs_s),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .rst_hit(rst_hit)
  );

  sar_core #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .SINGLE_CH(SINGLE_CH)) u_core (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sdi_s(sdi_s), .cmp_below_s(cmp_s),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .rst_hit(rst_hit),
    .state(state), .trial(trial), .chan(chan), .sdo(sdo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= ~cs_s;
  end

  assign sdo_oe = oe_q;
  assign busy   = (state == ST_TRACK) || (state == ST_CONV);
  assign track  = (state == ST_TRACK);
endmodule

// File: rtl/sar_seq_checker.sv
module sar_seq_checker
  import sar_seq_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_s,
  input logic              fall_ev,
  input logic              rst_hit,
  input seq_state_t        state,
  input logic [WIDTH-1:0]  trial,
  input logic [ADDR_W-1:0] chan,
  input logic              sdo,
  input logic              busy,
  input logic              track
);
  assert_chan_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(chan));

  assert_track_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    track && fall_ev && !cs_s && !rst_hit |=> !track);

  assert_trial_waits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONV) && !fall_ev && !rst_hit |=> $stable(trial));

  assert_busy_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !$past(rst_hit) |-> (state == ST_REPLAY) || (state == ST_HOLD));

  assert_hold_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) && ($past(state) == ST_HOLD) |-> $stable(sdo));

  assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s && !rst_hit && (state != ST_HOLD) |=> $stable(state));

  assert_reset_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_hit |=> (state == ST_IDLE) && (chan == '0));
endmodule

bind sar_serial_seq sar_seq_checker #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .fall_ev(fall_ev), .rst_hit(rst_hit),
  .state(state), .trial(trial), .chan(chan), .sdo(sdo), .busy(busy), .track(track)
);

// File: tb/tb_sar_serial_seq.sv
module tb_sar_serial_seq;
  localparam int HALF = 6;
  // entry: {all_below, addr[2:0], level[7:0]}
  localparam logic [11:0] VEC [8] = '{
    {1'b0, 3'd0, 8'h00}, {1'b0, 3'd1, 8'hFF}, {1'b0, 3'd2, 8'hA5},
    {1'b0, 3'd3, 8'h5A}, {1'b0, 3'd4, 8'h80}, {1'b0, 3'd5, 8'h7F},
    {1'b0, 3'd6, 8'h01}, {1'b1, 3'd7, 8'hC3}
  };

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0, cmp_below = 1'b0;
  logic sdo, sdo_oe, busy, track;
  logic [2:0] chan;
  logic s_sdo, s_oe, s_busy, s_track;
  logic [2:0] s_chan;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] mt;
  int midx;
  bit eb;

  always #10 clk = ~clk;

  sar_serial_seq dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .cmp_below(cmp_below),
    .sdo(sdo), .sdo_oe(sdo_oe), .busy(busy), .track(track), .chan(chan)
  );

  sar_serial_seq #(.SINGLE_CH(1'b1)) dut_single (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .cmp_below(cmp_below),
    .sdo(s_sdo), .sdo_oe(s_oe), .busy(s_busy), .track(s_track), .chan(s_chan)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cyc(input logic d);
    sdi = d; sclk = 1'b1; half(); sclk = 1'b0; half();
  endtask

  // bench model of one decision: sets cmp_below and the expected bit
  task automatic decide(input logic [7:0] lvl, input bit z);
    cmp_below = z ? 1'b1 : (lvl < mt);
    eb = ~cmp_below;
    if (cmp_below) mt[midx] = 1'b0;
    if (midx > 0) mt[midx-1] = 1'b1;
    midx--;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic do_conv(input logic [2:0] a, input logic [7:0] lvl, input bit z,
                         input bit single, input bit pause);
    logic [7:0] got;
    int npre;
    got = '0;
    cs_n = 1'b0; half(); half();
    chk("R10 drive enabled when selected", single ? s_oe : sdo_oe, 1);
    for (int n = 0; n < 4; n++) cyc(1'b0);
    chk("R2 zero bits do not start", single ? s_busy : busy, 0);
    mt = 8'h80; midx = 7;
    npre = single ? 1 : 4;
    for (int k = 0; k < npre; k++) begin
      sdi = (k == 0) ? 1'b1 : a[3-k];
      sclk = 1'b1; half();
      if (k == npre - 1) begin
        chk("R4 track open", single ? s_track : track, 1);
        chk("R8 busy from track", single ? s_busy : busy, 1);
        decide(lvl, z);
      end
      sclk = 1'b0; half();
      if (k == npre - 1) begin
        got[7] = single ? s_sdo : sdo;
        chk("R6 first decision", got[7], eb);
        chk("R4 track closed after half clock", single ? s_track : track, 0);
      end
    end
    for (int i = 6; i >= 0; i--) begin
      sdi = 1'b0; sclk = 1'b1; half();
      decide(lvl, z);
      sclk = 1'b0; half();
      got[i] = single ? s_sdo : sdo;
      chk("R6 decision bit", got[i], eb);
      if (pause && i == 4) begin
        cs_n = 1'b1; half();
        chk("R10 high impedance on deselect", sdo_oe, 0);
        chk("R10 paused not aborted", busy, 1);
        sclk = 1'b1; half(); sclk = 1'b0; half();
        cs_n = 1'b0; half();
        chk("R10 drive back on reselect", sdo_oe, 1);
        chk("R11 short overlap no reset", busy, 1);
        chk("R10 last bit kept", sdo, got[4]);
      end
      if (i == 0) chk("R8 busy ends with last bit", single ? s_busy : busy, 0);
    end
    if (z) chk("R7 all-below gives zero", got, 0);
    else   chk("R5 result equals level", got, lvl);
    if (!single) chk("R3 channel latched", chan, a);
    for (int i = 1; i < 8; i++) begin
      cyc(1'b0);
      if (single) chk("R12 no replay, bit0 held", s_sdo, mt[0]);
      else        chk("R9 LSB-first replay", sdo, mt[i]);
    end
    for (int n = 0; n < 2; n++) begin
      cyc(1'b0);
      if (single) chk("R12 bit0 held", s_sdo, mt[0]);
      else        chk("R9 bit7 held", sdo, mt[7]);
    end
    cs_n = 1'b1; half();
    chk("R10 high impedance after word", single ? s_oe : sdo_oe, 0);
    half();
  endtask

  task automatic long_reset();
    cs_n = 1'b1; half();
    sclk = 1'b1; repeat (24) @(negedge clk);
    sclk = 1'b0; half();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    half();
    chk("R1 reset oe", sdo_oe, 0);
    chk("R1 reset sdo", sdo, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset track", track, 0);
    chk("R1 reset chan", chan, 0);

    for (int n = 0; n < 8; n++)
      do_conv(VEC[n][10:8], VEC[n][7:0], VEC[n][11], 1'b0, n == 2);

    // R11: abort mid-conversion with a long overlap
    cs_n = 1'b0; half();
    cyc(1'b1); cyc(1'b1); cyc(1'b0); cyc(1'b1);
    cmp_below = 1'b0; cyc(1'b0);
    chk("R11 conversion running before reset", busy, 1);
    long_reset();
    cs_n = 1'b0; half();
    chk("R11 busy cleared", busy, 0);
    chk("R11 track cleared", track, 0);
    chk("R11 chan cleared", chan, 0);
    cs_n = 1'b1; half();
    do_conv(3'd6, 8'h3C, 1'b0, 1'b0, 1'b0);

    // R12: single-channel variant
    long_reset();
    do_conv(3'd0, 8'h6B, 1'b0, 1'b1, 1'b0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule